// File: doc/BRIEF.md
# SPI Target with Shared-Pointer Ring Buffers

This block is the serial end of a host-command link. An external controller drives SCK, an active-low select and MOSI in SPI mode 0. Every completed byte is stored into an input ring. In the same byte slot, the byte at the same position of an output ring is shifted out on MISO. The local side fills the output ring and drains the input ring through a plain address/data port. It reads one shared byte pointer and services a small event register that drives an interrupt line.

All serial pins are brought into the system clock through two-flop synchronisers and sampled there. The whole block therefore runs on one clock, and the local side always sees a coherent pointer. SCK must run well below the system clock: each SCK phase must last at least three system clocks.

Events cover these conditions:
- the pointer passing the middle and the end of the ring;
- a programmable byte count since select went low, normally set to the size of a request header;
- both select edges, even with no SCK activity;
- the end of a transaction in which clocking took place.

Top module: `spit_target`

## Requirements
- R1: MOSI is captured MSB first on SCK rising edges. MISO presents bit 7 of the current output byte when select falls, and moves to the next bit only on SCK falling edges.
- R2: One pointer indexes both rings. The byte received while the pointer is N is written to input location N, and the byte sent in that slot is output location N.
- R3: The pointer (`buf_ptr`) advances by exactly one per completed 8-bit byte and holds otherwise.
- R4: With `cfg_wrap`=1, a byte completed at location DEPTH-1 returns the pointer to 0. With `cfg_wrap`=0 the pointer parks at DEPTH; further bytes are not stored and MISO sends zeros.
- R5: Status bit 0 (half) sets when a byte completes at location DEPTH/2-1. Status bit 1 (full) sets when a byte completes at location DEPTH-1.
- R6: Status bit 2 (level) sets when the count of bytes completed since select fell equals `lvl_thresh`. This needs a nonzero threshold and `lvl_dis`=0.
- R7: Status bit 3 sets on a select falling edge and bit 4 on a select rising edge, with or without SCK activity.
- R8: Status bit 5 (end of read) sets on a select rising edge only if at least one SCK rising edge occurred while select was low.
- R9: `busy` is high while the synchronised select is low.
- R10: While `cfg_en`=0 the pointer is 0, all status bits are 0, and pin activity raises no event.
- R11: Status bits stay set until a 1 is written at the same position of `evt_clr`. Clearing one bit leaves the others unchanged.
- R12: `irq` is high exactly when some status bit and its `evt_en` bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Block enable; low clears pointer and status |
| cfg_wrap | input | 1 | Pointer wraps to 0 after the last location |
| lvl_dis | input | 1 | Gates the level event while its threshold changes |
| lvl_thresh | input | PW+1 | Byte count for the level event (0 = never) |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Target select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | High while selected, for an external pad driver |
| loc_addr | input | PW | Local ring address |
| loc_wdata | input | 8 | Local write data |
| loc_ibuf_we | input | 1 | Local write to the input ring |
| loc_obuf_we | input | 1 | Local write to the output ring |
| loc_ibuf_rdata | output | 8 | Input ring byte at `loc_addr` |
| loc_obuf_rdata | output | 8 | Output ring byte at `loc_addr` |
| buf_ptr | output | PW+1 | Shared byte pointer (DEPTH means parked) |
| evt_en | input | 6 | Per-event interrupt enable |
| evt_clr | input | 6 | Write-1-to-clear strobe for status |
| evt_status | output | 6 | Event status bits |
| busy | output | 1 | Select is asserted |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH=16, so PW=4 and the middle of the ring is location 8. This coincides with a level threshold of 8. It lets a single transaction of 16 bytes cross the half and full points, wrap, and park without wrap. The level event is also tried at threshold 3 and with the disable set. Each SCK phase lasts four system clocks, which exercises the synchroniser path at a realistic oversampling ratio.

// File: rtl/spit_pkg.sv
// Shared definitions: event status bit positions for the SPI target.
package spit_pkg;
    localparam int EV_HALF = 0;   // pointer passed middle of ring
    localparam int EV_FULL = 1;   // pointer passed end of ring
    localparam int EV_LVL  = 2;   // programmable byte count reached
    localparam int EV_CSF  = 3;   // select fell
    localparam int EV_CSR  = 4;   // select rose
    localparam int EV_EOR  = 5;   // select rose after clocking
    localparam int EV_W    = 6;
endpackage

// File: rtl/spit_sync.sv
// Two-flop synchroniser for a vector of independent asynchronous pins.
// Assumes each bit is sampled on its own; no multi-bit coherency.
module spit_sync #(
    parameter int              WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic s1, s2;
        // Two-stage capture of pin i
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/spit_serdes.sv
// Mode-0 bit engine working on synchronised pins: edge detection,
// MSB-first shift-in on SCK rise, MISO update on SCK fall.
// Assumes each SCK phase lasts at least three system clocks.
module spit_serdes (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       sck_s,
    input  logic       cs_act,
    input  logic       mosi_s,
    input  logic [7:0] tx_byte,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic       miso,
    output logic       sck_fall,
    output logic       cs_start,
    output logic       cs_end,
    output logic       sck_seen
);
    logic       sck_q, cs_q, sck_rise;
    logic [2:0] bit_cnt;
    logic [6:0] shreg;

    // Previous pin values for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b0;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_act;
        end
    end

    assign sck_rise  = en & cs_act & sck_s & ~sck_q;
    assign sck_fall  = en & cs_act & ~sck_s & sck_q;
    assign cs_start  = en & cs_act & ~cs_q;
    assign cs_end    = en & ~cs_act & cs_q;
    assign byte_done = sck_rise & (bit_cnt == 3'd7);
    assign rx_byte   = {shreg, mosi_s};

    // Shift, bit counting and MISO bit selection
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            miso     <= 1'b0;
            sck_seen <= 1'b0;
        end else if (cs_start) begin
            bit_cnt  <= '0;
            sck_seen <= 1'b0;
            miso     <= tx_byte[7];
        end else begin
            if (sck_rise) begin
                shreg    <= {shreg[5:0], mosi_s};
                bit_cnt  <= bit_cnt + 3'd1;
                sck_seen <= 1'b1;
            end
            if (sck_fall) begin
                miso <= tx_byte[3'd7 - bit_cnt];
            end
        end
    end
endmodule

// File: rtl/spit_ring.sv
// Input and output byte rings sharing one pointer. The pointer carries
// one extra bit: value DEPTH means parked (no wrap), nothing is stored.
// Assumes DEPTH is a power of two, at least 4.
module spit_ring #(
    parameter  int DEPTH = 128,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          wrap,
    input  logic          byte_done,
    input  logic [7:0]    rx_byte,
    input  logic [PW-1:0] loc_addr,
    input  logic [7:0]    loc_wdata,
    input  logic          loc_ibuf_we,
    input  logic          loc_obuf_we,
    output logic [7:0]    loc_ibuf_rdata,
    output logic [7:0]    loc_obuf_rdata,
    output logic [7:0]    tx_byte,
    output logic [PW:0]   ptr,
    output logic          half_hit,
    output logic          full_hit
);
    localparam logic [PW-1:0] HALF_LAST = PW'(DEPTH / 2 - 1);
    localparam logic [PW-1:0] LAST      = PW'(DEPTH - 1);

    logic [7:0]    ibuf [DEPTH];
    logic [7:0]    obuf [DEPTH];
    logic [PW-1:0] idx;
    logic          parked, wr_spi;

    assign idx      = ptr[PW-1:0];
    assign parked   = ptr[PW];
    assign wr_spi   = byte_done & ~parked;
    assign half_hit = wr_spi & (idx == HALF_LAST);
    assign full_hit = wr_spi & (idx == LAST);
    assign tx_byte  = parked ? 8'h00 : obuf[idx];
    assign loc_ibuf_rdata = ibuf[loc_addr];
    assign loc_obuf_rdata = obuf[loc_addr];

    // Shared pointer: advance per byte, wrap or park at the end
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            ptr <= '0;
        end else if (wr_spi) begin
            if (idx == LAST) ptr <= wrap ? '0 : (PW+1)'(DEPTH);
            else             ptr <= ptr + 1'b1;
        end
    end

    // Input ring: serial byte has priority over a local write
    always_ff @(posedge clk) begin
        if (wr_spi)           ibuf[idx]      <= rx_byte;
        else if (loc_ibuf_we) ibuf[loc_addr] <= loc_wdata;
    end

    // Output ring: written only from the local side
    always_ff @(posedge clk) begin
        if (loc_obuf_we) obuf[loc_addr] <= loc_wdata;
    end
endmodule

// File: rtl/spit_target.sv
// SPI mode-0 target with shared-pointer input/output rings and an event
// register. All logic runs on clk; pins are synchronised on entry.
// Assumes SCK phases of at least three clk periods.
module spit_target #(
    parameter  int DEPTH = 128,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_en,
    input  logic                  cfg_wrap,
    input  logic                  lvl_dis,
    input  logic [PW:0]           lvl_thresh,
    input  logic                  spi_sck,
    input  logic                  spi_cs_n,
    input  logic                  spi_mosi,
    output logic                  spi_miso,
    output logic                  spi_miso_oe,
    input  logic [PW-1:0]         loc_addr,
    input  logic [7:0]            loc_wdata,
    input  logic                  loc_ibuf_we,
    input  logic                  loc_obuf_we,
    output logic [7:0]            loc_ibuf_rdata,
    output logic [7:0]            loc_obuf_rdata,
    output logic [PW:0]           buf_ptr,
    input  logic [spit_pkg::EV_W-1:0] evt_en,
    input  logic [spit_pkg::EV_W-1:0] evt_clr,
    output logic [spit_pkg::EV_W-1:0] evt_status,
    output logic                  busy,
    output logic                  irq
);
    import spit_pkg::*;

    logic [2:0]      pins_s;
    logic            sck_s, cs_n_s, mosi_s, cs_act;
    logic            byte_done, sck_fall, cs_start, cs_end, sck_seen;
    logic [7:0]      rx_byte, tx_byte;
    logic            half_hit, full_hit, lvl_hit;
    logic [PW:0]     lvl_cnt;
    logic [EV_W-1:0] ev_set;

    spit_sync #(.WIDTH(3), .RST_VAL(3'b010)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .d({spi_sck, spi_cs_n, spi_mosi}), .q(pins_s)
    );
    assign {sck_s, cs_n_s, mosi_s} = pins_s;
    assign cs_act      = ~cs_n_s;
    assign busy        = cs_act;
    assign spi_miso_oe = cs_act;

    spit_serdes serdes_i (
        .clk(clk), .rst_n(rst_n), .en(cfg_en),
        .sck_s(sck_s), .cs_act(cs_act), .mosi_s(mosi_s), .tx_byte(tx_byte),
        .byte_done(byte_done), .rx_byte(rx_byte), .miso(spi_miso),
        .sck_fall(sck_fall), .cs_start(cs_start), .cs_end(cs_end),
        .sck_seen(sck_seen)
    );

    spit_ring #(.DEPTH(DEPTH)) ring_i (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .wrap(cfg_wrap),
        .byte_done(byte_done), .rx_byte(rx_byte),
        .loc_addr(loc_addr), .loc_wdata(loc_wdata),
        .loc_ibuf_we(loc_ibuf_we), .loc_obuf_we(loc_obuf_we),
        .loc_ibuf_rdata(loc_ibuf_rdata), .loc_obuf_rdata(loc_obuf_rdata),
        .tx_byte(tx_byte), .ptr(buf_ptr),
        .half_hit(half_hit), .full_hit(full_hit)
    );

    // Bytes completed since select fell, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_en || cs_start) lvl_cnt <= '0;
        else if (byte_done && !(&lvl_cnt)) lvl_cnt <= lvl_cnt + 1'b1;
    end

    assign lvl_hit = byte_done & ~lvl_dis & (lvl_thresh != '0)
                   & ((lvl_cnt + 1'b1) == lvl_thresh);

    always_comb begin
        ev_set          = '0;
        ev_set[EV_HALF] = half_hit;
        ev_set[EV_FULL] = full_hit;
        ev_set[EV_LVL]  = lvl_hit;
        ev_set[EV_CSF]  = cs_start;
        ev_set[EV_CSR]  = cs_end;
        ev_set[EV_EOR]  = cs_end & sck_seen;
    end

    // Event status: write-1-to-clear, a new event wins over its clear
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_en) evt_status <= '0;
        else                   evt_status <= (evt_status & ~evt_clr) | ev_set;
    end

    assign irq = |(evt_status & evt_en);
endmodule

// File: rtl/spit_chk.sv
// Property checker for spit_target, attached by bind below.
module spit_chk #(
    parameter  int DEPTH = 128,
    localparam int PW    = $clog2(DEPTH)
) (
    input logic        clk,
    input logic        rst_n,
    input logic        en,
    input logic        wrap,
    input logic        byte_done,
    input logic        sck_fall,
    input logic        cs_start,
    input logic        cs_end,
    input logic        sck_seen,
    input logic        miso,
    input logic [PW:0] ptr,
    input logic [5:0]  status
);
    localparam logic [PW:0] LAST = (PW+1)'(DEPTH - 1);

    a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && byte_done && ptr < LAST) |=> (!en || ptr == $past(ptr) + 1'b1));

    a_r3_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !byte_done) |=> (!en || ptr == $past(ptr)));

    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wrap && byte_done && ptr == LAST) |=> (!en || ptr == '0));

    a_r10_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (ptr == '0 && status == '0));

    a_r7_cs_fall_evt: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cs_start) |=> (!en || status[3]));

    a_r7_cs_rise_evt: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cs_end) |=> (!en || status[4]));

    a_r8_eor_needs_clk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cs_end && !sck_seen && !status[5]) |=> !status[5]);

    a_r1_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sck_fall && !cs_start) |=> (!en || $stable(miso)));
endmodule

bind spit_target spit_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .wrap(cfg_wrap),
    .byte_done(byte_done), .sck_fall(sck_fall), .cs_start(cs_start),
    .cs_end(cs_end), .sck_seen(sck_seen), .miso(spi_miso),
    .ptr(buf_ptr), .status(evt_status)
);

// File: tb/spit_target_tb_top.sv
`timescale 1ns/1ps
module spit_target_tb_top;
    localparam int DEPTH = 16;
    localparam int PW    = 4;
    localparam int SET   = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_en = 1'b0, cfg_wrap = 1'b1, lvl_dis = 1'b0;
    logic [PW:0] lvl_thresh = 5'd8;
    logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic spi_miso, spi_miso_oe;
    logic [PW-1:0] loc_addr = '0;
    logic [7:0] loc_wdata = '0;
    logic loc_ibuf_we = 1'b0, loc_obuf_we = 1'b0;
    logic [7:0] loc_ibuf_rdata, loc_obuf_rdata;
    logic [PW:0] buf_ptr;
    logic [5:0] evt_en = 6'h3f, evt_clr = '0, evt_status;
    logic busy, irq;

    always #2 clk = ~clk;

    spit_target #(.DEPTH(DEPTH)) dut_i (.*);

    int n_chk = 0, n_fail = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // Behavioural reference model
    int m_obuf[DEPTH];
    int m_ibuf[DEPTH];
    int m_ptr = 0, m_cnt = 0;
    bit [5:0] m_st = '0;
    bit m_seen = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the model, off the active edge
    always @(posedge clk) begin
        #1;
        if (cmp_on && !done) begin
            chk(buf_ptr == m_ptr[PW:0], "R3 pointer", buf_ptr, m_ptr);
            chk(evt_status == m_st, "R11 status", evt_status, m_st);
            chk(irq == |(m_st & evt_en), "R12 irq", irq, |(m_st & evt_en));
        end
    end

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic obuf_wr(input int a, input int v);
        @(negedge clk);
        loc_addr = a[PW-1:0]; loc_wdata = v[7:0]; loc_obuf_we = 1'b1;
        @(negedge clk);
        loc_obuf_we = 1'b0;
        m_obuf[a] = v;
    endtask

    task automatic ibuf_wr(input int a, input int v);
        @(negedge clk);
        loc_addr = a[PW-1:0]; loc_wdata = v[7:0]; loc_ibuf_we = 1'b1;
        @(negedge clk);
        loc_ibuf_we = 1'b0;
        m_ibuf[a] = v;
    endtask

    task automatic check_ibuf(input string tag);
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            loc_addr = a[PW-1:0];
            #1;
            chk(loc_ibuf_rdata == m_ibuf[a][7:0], tag, loc_ibuf_rdata, m_ibuf[a]);
        end
    endtask

    task automatic cs_low();
        cmp_on = 1'b0;
        @(negedge clk); spi_cs_n = 1'b0;
        settle(SET);
        if (cfg_en) begin m_st[3] = 1'b1; m_cnt = 0; m_seen = 1'b0; end
        chk(busy == 1'b1, "R9 busy while selected", busy, 1);
        cmp_on = 1'b1;
    endtask

    task automatic cs_high();
        cmp_on = 1'b0;
        @(negedge clk); spi_cs_n = 1'b1;
        settle(SET);
        if (cfg_en) begin m_st[4] = 1'b1; if (m_seen) m_st[5] = 1'b1; end
        chk(busy == 1'b0, "R9 busy released", busy, 0);
        cmp_on = 1'b1;
    endtask

    task automatic xfer(input int tx);
        int exp;
        cmp_on = 1'b0;
        exp = (m_ptr >= DEPTH) ? 0 : m_obuf[m_ptr];
        for (int b = 7; b >= 0; b--) begin
            @(negedge clk); spi_mosi = tx[b];
            chk(spi_miso == exp[b], "R1 miso bit", spi_miso, exp[b]);
            spi_sck = 1'b1; settle(SET);
            spi_sck = 1'b0; settle(SET);
        end
        m_seen = 1'b1;
        if (m_ptr < DEPTH) begin
            m_ibuf[m_ptr] = tx & 8'hff;
            if (m_ptr == DEPTH/2 - 1) m_st[0] = 1'b1;
            if (m_ptr == DEPTH - 1) begin
                m_st[1] = 1'b1;
                m_ptr = cfg_wrap ? 0 : DEPTH;
            end else m_ptr++;
        end
        if (m_cnt < 31) begin
            m_cnt++;
            if (!lvl_dis && lvl_thresh != 0 && m_cnt == int'(lvl_thresh)) m_st[2] = 1'b1;
        end
        cmp_on = 1'b1;
    endtask

    task automatic clear(input bit [5:0] mask);
        cmp_on = 1'b0;
        @(negedge clk); evt_clr = mask;
        @(negedge clk); evt_clr = '0;
        m_st &= ~mask;
        cmp_on = 1'b1;
    endtask

    task automatic set_en(input bit v);
        cmp_on = 1'b0;
        @(negedge clk); cfg_en = v;
        settle(2);
        if (!v) begin m_ptr = 0; m_st = '0; m_cnt = 0; m_seen = 1'b0; end
        cmp_on = 1'b1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        settle(5);
        rst_n = 1'b1;
        settle(2);
        // Reset state
        chk(buf_ptr == 0, "R10 reset pointer", buf_ptr, 0);
        chk(evt_status == 0, "R10 reset status", evt_status, 0);
        chk(irq == 0, "R12 reset irq", irq, 0);
        chk(busy == 0, "R9 reset busy", busy, 0);
        cmp_on = 1'b1;

        // Select activity while disabled raises nothing
        cs_low(); cs_high();
        chk(evt_status == 0, "R10 disabled no events", evt_status, 0);

        set_en(1'b1);
        for (int a = 0; a < DEPTH; a++) obuf_wr(a, (a * 37 + 5) & 8'hff);
        for (int a = 0; a < DEPTH; a++) ibuf_wr(a, 0);

        // Select pulse without clocks
        cs_low();
        chk(evt_status[3] == 1'b1, "R7 select fall event", evt_status[3], 1);
        cs_high();
        chk(evt_status[4] == 1'b1, "R7 select rise event no clocks", evt_status[4], 1);
        chk(evt_status[5] == 1'b0, "R8 no end-of-read without clocks", evt_status[5], 0);
        clear(6'h3f);

        // Ten bytes: half and level at byte 8
        cs_low();
        for (int i = 0; i < 10; i++) begin
            xfer((i * 29 + 100) & 8'hff);
            if (i == 6) begin
                chk(evt_status[0] == 0, "R5 half not before middle", evt_status[0], 0);
                chk(evt_status[2] == 0, "R6 level not before threshold", evt_status[2], 0);
            end
        end
        chk(evt_status[0] == 1, "R5 half at middle", evt_status[0], 1);
        chk(evt_status[2] == 1, "R6 level at 8 bytes", evt_status[2], 1);
        chk(buf_ptr == 10, "R3 pointer after ten bytes", buf_ptr, 10);
        cs_high();
        chk(evt_status[5] == 1, "R8 end-of-read after clocks", evt_status[5], 1);
        check_ibuf("R2 input ring contents");

        // Partial clear keeps other bits
        clear(6'b000101);
        chk(evt_status == 6'b111000, "R11 partial clear", evt_status, 6'b111000);
        evt_en = 6'b000010;
        settle(2);
        chk(irq == 0, "R12 masked irq low", irq, 0);
        evt_en = 6'h3f;
        clear(6'h3f);

        // Wrap through the end
        cs_low();
        for (int i = 0; i < 6; i++) xfer((i * 11 + 7) & 8'hff);
        chk(evt_status[1] == 1, "R5 full at end", evt_status[1], 1);
        chk(buf_ptr == 0, "R4 wrap to zero", buf_ptr, 0);
        cs_high();
        check_ibuf("R2 ring after wrap");
        clear(6'h3f);

        // No wrap: park and ignore extra bytes
        cfg_wrap = 1'b0;
        cs_low();
        for (int i = 0; i < 18; i++) xfer((i * 53 + 1) & 8'hff);
        chk(buf_ptr == DEPTH, "R4 pointer parked", buf_ptr, DEPTH);
        cs_high();
        check_ibuf("R4 extra bytes not stored");
        clear(6'h3f);

        // Disable clears pointer and status
        cs_low(); cs_high();
        set_en(1'b0);
        chk(buf_ptr == 0, "R10 disable pointer", buf_ptr, 0);
        chk(evt_status == 0, "R10 disable status", evt_status, 0);
        set_en(1'b1);
        cfg_wrap = 1'b1;

        // Level event gated by disable
        lvl_dis = 1'b1;
        cs_low();
        for (int i = 0; i < 9; i++) xfer(8'hA5 ^ i);
        chk(evt_status[2] == 0, "R6 level gated", evt_status[2], 0);
        cs_high();
        clear(6'h3f);

        // Level at threshold 3
        lvl_dis = 1'b0;
        lvl_thresh = 5'd3;
        cs_low();
        xfer(8'h11); xfer(8'h22);
        chk(evt_status[2] == 0, "R6 level before threshold 3", evt_status[2], 0);
        xfer(8'h33);
        chk(evt_status[2] == 1, "R6 level at threshold 3", evt_status[2], 1);
        cs_high();

        settle(4);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule